// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Source

This block collects 96 interrupt request lines, grouped into three banks of 32, and presents them to one processor through a single interrupt output and a small word-addressed register file. Every source has a pending bit, an enable bit and a block (mask) bit. A source counts as active when it is pending, enabled and not blocked. The interrupt output is high while any source is active. A vector register reports the lowest-numbered active source.

Sources 1 to 95 are level inputs: their pending bits simply follow the request lines, one clock behind. Source 0 is an external line with a selectable trigger: low level, high level, falling edge or rising edge. Once its pending bit is set it holds until software writes a one to it. The vector register reads zero both when nothing is active and when source 0 wins. Software tells these two cases apart by reading pending bit 0.

The register interface is a plain single-cycle bus. Reads are combinational from the address, and writes take effect at the clock edge that samples the write strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all enable bits, all block bits, the trigger select and the guard bit read 0, and `irqOut` is low.
- R2: Pending bit n (bank n/32 at byte offset 0x10 + 4·(n/32), bit n%32) for a source n in 1..95 equals the request input sampled at the previous rising clock edge.
- R3: A write of ones to a pending word leaves the pending bits of sources 1..95 unchanged; they keep following their inputs.
- R4: `irqOut` is high exactly when at least one source has its pending bit 1, its enable bit 1 and its block bit 0.
- R5: The vector register at offset 0x00 carries the index of the lowest-numbered active source in bits [8:2], with all other bits 0. It reads 0 when no source is active and when source 0 is the lowest active source.
- R6: The trigger select in bits [1:0] at offset 0x0C sets pending bit 0 at a clock edge where the condition holds: 0 means the input is low, 1 means it is high, 2 means a high-to-low change since the previous edge, 3 means a low-to-high change since the previous edge.
- R7: Pending bit 0 stays set until a write to offset 0x10 with bit 0 equal to 1. If a trigger condition occurs on the same edge as that write, the bit stays set.
- R8: The enable words at 0x40 + 4·b and the block words at 0x50 + 4·b (b = 0..2) read back the last value written, starting from the edge of the write.
- R9: The guard register at 0x08 stores bit 0 of the written data and reads it back with all other bits 0; it has no effect on delivery.
- R10: Offsets 0x20..0x28, bank slot 3 of any bank region, unmapped offsets and offsets with nonzero low two bits read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irqSrc | input | 96 | Request lines; bit 0 is the trigger-selectable source |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt line to the processor |

## Verification
A change on a request line reaches the pending bits, the vector word and `irqOut` one rising edge later, because only the pending register stands in the path. A register write is visible on the read port at once after the edge that samples the strobe. A source-0 trigger needs one edge to detect the condition, and an edge trigger also needs the level seen on the edge before. The bench drives inputs at the falling edge, steps exactly one rising edge, and reads back just after the next falling edge. It sweeps every source alone, walks pairs of sources to check priority, and takes source 0 through all four trigger modes, including a clear and a trigger on the same edge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Register kinds decoded from the bus address
  typedef enum logic [2:0] {
    RK_NONE,
    RK_VECTOR,
    RK_GUARD,
    RK_NMICFG,
    RK_PEND,
    RK_EN,
    RK_MASK
  } regKind_t;

  // Trigger selection for source 0
  typedef enum logic [1:0] {
    NMI_LOW  = 2'd0,
    NMI_HIGH = 2'd1,
    NMI_FALL = 2'd2,
    NMI_RISE = 2'd3
  } nmiMode_t;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    regKind_t   wrKind;
    regKind_t   rdKind;
    logic [1:0] bank;
  } busStrobe_t;

  // Address regions (byte address bits [7:4])
  localparam logic [3:0] REGION_CTRL  = 4'h0;
  localparam logic [3:0] REGION_PEND  = 4'h1;
  localparam logic [3:0] REGION_FPEND = 4'h2;
  localparam logic [3:0] REGION_EN    = 4'h4;
  localparam logic [3:0] REGION_MASK  = 4'h5;

  // Word slots inside the control region (byte address bits [3:2])
  localparam logic [1:0] SLOT_VECTOR = 2'd0;
  localparam logic [1:0] SLOT_GUARD  = 2'd2;
  localparam logic [1:0] SLOT_NMICFG = 2'd3;

endpackage

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int unsigned REQ_W = 96,
  localparam int unsigned IDX_W = $clog2(REQ_W)
) (
  input  logic [REQ_W-1:0] reqVec,
  output logic [IDX_W-1:0] winIdx,
  output logic             anyReq
);

  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    winIdx = '0;
    for (int i = REQ_W - 1; i >= 0; i--) begin
      if (reqVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyReq = |reqVec;

endmodule

// File: rtl/irqv_ctl.sv
module irqv_ctl
  import irqv_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BANKS  = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        stb
);

  logic [3:0] region;
  logic [1:0] slot;
  logic       hiZero;
  logic       aligned;
  logic       bankOk;
  regKind_t   kind;

  assign region  = busAddr[7:4];
  assign slot    = busAddr[3:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign bankOk  = (32'(slot) < BANKS);

  // Upper address bits, when present, must be zero
  generate
    if (ADDR_W > 8) begin : g_hi
      assign hiZero = ~|busAddr[ADDR_W-1:8];
    end else begin : g_nohi
      assign hiZero = 1'b1;
    end
  endgenerate

  always_comb begin
    kind = RK_NONE;
    if (hiZero && aligned) begin
      unique case (region)
        REGION_CTRL: begin
          case (slot)
            SLOT_VECTOR: kind = RK_VECTOR;
            SLOT_GUARD:  kind = RK_GUARD;
            SLOT_NMICFG: kind = RK_NMICFG;
            default:     kind = RK_NONE;
          endcase
        end
        REGION_PEND: kind = bankOk ? RK_PEND : RK_NONE;
        REGION_EN:   kind = bankOk ? RK_EN   : RK_NONE;
        REGION_MASK: kind = bankOk ? RK_MASK : RK_NONE;
        default:     kind = RK_NONE;
      endcase
    end
  end

  always_comb begin
    stb.rdKind = kind;
    stb.bank   = slot;
    stb.wrKind = RK_NONE;
    if (busWe && kind != RK_VECTOR) stb.wrKind = kind;
  end

endmodule

// File: rtl/irqv_dp.sv
module irqv_dp
  import irqv_pkg::*;
#(
  parameter int unsigned BANKS  = 3,
  parameter int unsigned BANK_W = 32,
  localparam int unsigned NUM_SRC = BANKS * BANK_W,
  localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  busStrobe_t         stb,
  input  logic [BANK_W-1:0]  busWdata,
  input  logic [IDX_W-1:0]   vecIdx,
  output logic [BANK_W-1:0]  busRdata,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] enVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] activeVec
);

  logic [NUM_SRC-1:0] pendQ, enQ, maskQ;
  logic [1:0]         nmiCfgQ;
  logic               guardQ;
  logic               nmiPrevQ;
  logic               nmiHit;
  logic               nmiClr;
  logic               pend0Next;

  // Source 0 trigger detection
  always_comb begin
    unique case (nmiMode_t'(nmiCfgQ))
      NMI_LOW:  nmiHit = ~irqSrc[0];
      NMI_HIGH: nmiHit =  irqSrc[0];
      NMI_FALL: nmiHit =  nmiPrevQ & ~irqSrc[0];
      NMI_RISE: nmiHit = ~nmiPrevQ &  irqSrc[0];
      default:  nmiHit = 1'b0;
    endcase
  end

  assign nmiClr    = (stb.wrKind == RK_PEND) && (stb.bank == 2'd0) && busWdata[0];
  assign pend0Next = nmiHit | (pendQ[0] & ~nmiClr);

  // Pending: source 0 sticky, others follow their level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ    <= '0;
      nmiPrevQ <= 1'b0;
    end else begin
      pendQ    <= {irqSrc[NUM_SRC-1:1], pend0Next};
      nmiPrevQ <= irqSrc[0];
    end
  end

  // Enable and block words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ   <= '0;
      maskQ <= '0;
    end else begin
      for (int b = 0; b < int'(BANKS); b++) begin
        if (stb.wrKind == RK_EN && stb.bank == 2'(b))
          enQ[b*BANK_W +: BANK_W] <= busWdata;
        if (stb.wrKind == RK_MASK && stb.bank == 2'(b))
          maskQ[b*BANK_W +: BANK_W] <= busWdata;
      end
    end
  end

  // Control words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmiCfgQ <= 2'd0;
      guardQ  <= 1'b0;
    end else begin
      if (stb.wrKind == RK_NMICFG) nmiCfgQ <= busWdata[1:0];
      if (stb.wrKind == RK_GUARD)  guardQ  <= busWdata[0];
    end
  end

  assign activeVec = pendQ & enQ & ~maskQ;
  assign pendVec   = pendQ;
  assign enVec     = enQ;
  assign maskVec   = maskQ;

  // Read mux
  always_comb begin
    busRdata = '0;
    unique case (stb.rdKind)
      RK_VECTOR: busRdata[IDX_W+1:2] = vecIdx;
      RK_GUARD:  busRdata[0]         = guardQ;
      RK_NMICFG: busRdata[1:0]       = nmiCfgQ;
      RK_PEND, RK_EN, RK_MASK: begin
        for (int b = 0; b < int'(BANKS); b++) begin
          if (stb.bank == 2'(b)) begin
            if (stb.rdKind == RK_PEND) busRdata = pendQ[b*BANK_W +: BANK_W];
            if (stb.rdKind == RK_EN)   busRdata = enQ[b*BANK_W +: BANK_W];
            if (stb.rdKind == RK_MASK) busRdata = maskQ[b*BANK_W +: BANK_W];
          end
        end
      end
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned BANKS  = 3,
  parameter int unsigned BANK_W = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned NUM_SRC = BANKS * BANK_W,
  localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [BANK_W-1:0]  busWdata,
  output logic [BANK_W-1:0]  busRdata,
  output logic               irqOut
);

  busStrobe_t         stb;
  logic [NUM_SRC-1:0] pendVec, enVec, maskVec, activeVec;
  logic [IDX_W-1:0]   vecIdx;
  logic               vecAny;

  irqv_ctl #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_ctl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb)
  );

  irqv_dp #(.BANKS(BANKS), .BANK_W(BANK_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .irqSrc    (irqSrc),
    .stb       (stb),
    .busWdata  (busWdata),
    .vecIdx    (vecIdx),
    .busRdata  (busRdata),
    .pendVec   (pendVec),
    .enVec     (enVec),
    .maskVec   (maskVec),
    .activeVec (activeVec)
  );

  irqv_prio #(.REQ_W(NUM_SRC)) u_prio (
    .reqVec (activeVec),
    .winIdx (vecIdx),
    .anyReq (vecAny)
  );

  assign irqOut = vecAny;

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int unsigned NUM_SRC = 96,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irqSrc,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] enVec,
  input logic [NUM_SRC-1:0] maskVec
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (enVec == '0 && maskVec == '0 && !irqOut));

  // R2
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pendVec[NUM_SRC-1:1] == $past(irqSrc[NUM_SRC-1:1])));

  // R4
  deliver_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> ((pendVec & enVec & ~maskVec) != '0));

  // R5
  vector_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqOut && busAddr == ADDR_W'(0)) |-> (busRdata == '0));

  // R5
  vector_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(0)) |-> (busRdata[1:0] == 2'b00 && busRdata[DATA_W-1:9] == '0));

  // R7
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendVec[0] && !(busWe && busAddr == ADDR_W'(8'h10) && busWdata[0])) |=> pendVec[0]);

  // R8
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(8'h40)) |=> (enVec[DATA_W-1:0] == $past(busWdata)));

endmodule

bind irq_vector_ctrl irqv_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .DATA_W  (BANK_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irqSrc   (irqSrc),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .pendVec  (pendVec),
  .enVec    (enVec),
  .maskVec  (maskVec)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

  localparam int NSRC = 96;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] irqSrc;
  logic [7:0]      busAddr;
  logic            busWe;
  logic [31:0]     busWdata;
  logic [31:0]     busRdata;
  logic            irqOut;

  int nChecks = 0;
  int nErrs   = 0;
  bit done    = 1'b0;

  irq_vector_ctrl dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .irqSrc   (irqSrc),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr  = a;
    busWdata = d;
    busWe    = 1'b1;
    tick();
    busWe    = 1'b0;
  endtask

  task automatic chkRd(input string req, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    chk(req, busRdata, exp);
  endtask

  task automatic chkIrq(input string req, input logic exp);
    #1;
    chk(req, {31'd0, irqOut}, {31'd0, exp});
  endtask

  function automatic logic [NSRC-1:0] bitOf(input int n);
    return {{(NSRC-1){1'b0}}, 1'b1} << n;
  endfunction

  function automatic logic [7:0] pendAddr(input int n);
    return 8'(8'h10 + 4 * (n / 32));
  endfunction

  initial begin
    rst_n    = 1'b0;
    irqSrc   = bitOf(0);          // source 0 idles high (low-level mode at reset)
    busAddr  = 8'h00;
    busWe    = 1'b0;
    busWdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int b = 0; b < 3; b++) begin
      chkRd("R1 enable", 8'(8'h40 + 4 * b), 32'h0);
      chkRd("R1 mask",   8'(8'h50 + 4 * b), 32'h0);
    end
    chkRd("R1 trigger", 8'h0C, 32'h0);
    chkRd("R1 guard",   8'h08, 32'h0);
    chkIrq("R1 irqOut", 1'b0);

    // R10: unmapped and fast-pending offsets
    wr(8'h20, 32'hFFFF_FFFF);
    chkRd("R10 fast pend 0x20", 8'h20, 32'h0);
    chkRd("R10 fast pend 0x24", 8'h24, 32'h0);
    chkRd("R10 fast pend 0x28", 8'h28, 32'h0);
    wr(8'h4C, 32'hFFFF_FFFF);
    chkRd("R10 bank slot 3", 8'h4C, 32'h0);
    wr(8'h41, 32'hFFFF_FFFF);
    chkRd("R10 misaligned no write", 8'h40, 32'h0);
    chkRd("R10 misaligned read", 8'h41, 32'h0);
    chkRd("R10 unmapped 0x04", 8'h04, 32'h0);
    chkRd("R10 unmapped 0x60", 8'h60, 32'h0);

    // R9: guard bit
    wr(8'h08, 32'hFFFF_FFFF);
    chkRd("R9 guard set", 8'h08, 32'h1);
    chkIrq("R9 no delivery", 1'b0);
    wr(8'h08, 32'h2);
    chkRd("R9 guard bit0 only", 8'h08, 32'h0);

    // R8: enable and block words read back
    for (int b = 0; b < 3; b++) begin
      wr(8'(8'h40 + 4 * b), 32'hA5C3_0000 + 32'(b));
      wr(8'(8'h50 + 4 * b), 32'h3C5A_0F00 + 32'(b));
    end
    for (int b = 0; b < 3; b++) begin
      chkRd("R8 enable readback", 8'(8'h40 + 4 * b), 32'hA5C3_0000 + 32'(b));
      chkRd("R8 mask readback",   8'(8'h50 + 4 * b), 32'h3C5A_0F00 + 32'(b));
    end
    for (int b = 0; b < 3; b++) begin
      wr(8'(8'h40 + 4 * b), 32'hFFFF_FFFF);
      wr(8'(8'h50 + 4 * b), 32'h0);
    end
    chkRd("R8 enable all", 8'h48, 32'hFFFF_FFFF);

    // R2, R4, R5: each source alone
    for (int n = 1; n < NSRC; n++) begin
      irqSrc = bitOf(n) | bitOf(0);
      tick();
      chkRd("R2 pending sweep", pendAddr(n), 32'd1 << (n % 32));
      chkRd("R5 vector sweep", 8'h00, 32'(n) << 2);
      chkIrq("R4 irq sweep", 1'b1);
    end

    // R5: priority between pairs
    for (int n = 1; n < NSRC - 1; n++) begin
      irqSrc = bitOf(n) | bitOf(NSRC - 1) | bitOf(0);
      tick();
      chkRd("R5 priority vs top", 8'h00, 32'(n) << 2);
      irqSrc = bitOf(n) | bitOf(n + 1) | bitOf(0);
      tick();
      chkRd("R5 priority neighbour", 8'h00, 32'(n) << 2);
    end

    // R4: blocking and disabling
    irqSrc = bitOf(40) | bitOf(70) | bitOf(0);
    tick();
    chkRd("R5 two active", 8'h00, 32'd40 << 2);
    wr(8'h54, 32'h0000_0100);
    chkRd("R4 blocked 40", 8'h00, 32'd70 << 2);
    chkIrq("R4 irq with 70", 1'b1);
    wr(8'h48, ~32'h0000_0040);
    chkRd("R4 vector none", 8'h00, 32'h0);
    chkIrq("R4 irq none", 1'b0);
    chkRd("R2 blocked still pending", 8'h14, 32'h0000_0100);
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h54, 32'h0);
    chkIrq("R4 irq restored", 1'b1);

    // R3: clearing a level source has no lasting effect
    irqSrc = bitOf(5) | bitOf(0);
    tick();
    wr(8'h10, 32'hFFFF_FFFF);
    chkRd("R3 level not cleared", 8'h10, 32'h0000_0020);
    irqSrc = bitOf(0);
    tick();
    chkRd("R3 level drops", 8'h10, 32'h0);
    chkIrq("R4 idle", 1'b0);

    // R6, R7: source 0, high level
    wr(8'h0C, 32'h1);
    chkRd("R6 trigger readback", 8'h0C, 32'h1);
    tick();
    chkRd("R6 high level sets", 8'h10, 32'h1);
    chkRd("R5 vector for source 0", 8'h00, 32'h0);
    chkIrq("R4 source 0 delivered", 1'b1);
    irqSrc = bitOf(0) | bitOf(10);
    tick();
    chkRd("R5 source 0 beats 10", 8'h00, 32'h0);
    irqSrc = '0;
    tick();
    chkRd("R7 sticky after drop", 8'h10, 32'h1);
    wr(8'h10, 32'h1);
    chkRd("R7 cleared", 8'h10, 32'h0);
    chkIrq("R7 irq after clear", 1'b0);

    // R6: low level
    wr(8'h0C, 32'h0);
    tick();
    chkRd("R6 low level sets", 8'h10, 32'h1);
    irqSrc = bitOf(0);
    tick();
    wr(8'h10, 32'h1);
    chkRd("R7 low level cleared", 8'h10, 32'h0);

    // R6: rising edge
    irqSrc = '0;
    wr(8'h0C, 32'h3);
    wr(8'h10, 32'h1);
    chkRd("R6 rise mode cleared", 8'h10, 32'h0);
    tick();
    chkRd("R6 rise ignores low", 8'h10, 32'h0);
    irqSrc = bitOf(0);
    tick();
    chkRd("R6 rise sets", 8'h10, 32'h1);
    wr(8'h10, 32'h1);
    chkRd("R6 rise no retrigger while high", 8'h10, 32'h0);
    irqSrc = '0;
    tick();
    irqSrc = bitOf(0);
    wr(8'h10, 32'h1);
    chkRd("R7 set wins over clear", 8'h10, 32'h1);
    wr(8'h10, 32'h1);
    chkRd("R7 cleared after set", 8'h10, 32'h0);

    // R6: falling edge
    wr(8'h0C, 32'h2);
    chkRd("R6 fall idle", 8'h10, 32'h0);
    irqSrc = '0;
    tick();
    chkRd("R6 fall sets", 8'h10, 32'h1);
    wr(8'h10, 32'h1);
    chkRd("R6 fall no retrigger while low", 8'h10, 32'h0);
    irqSrc = bitOf(0);
    tick();
    chkRd("R6 fall ignores rise", 8'h10, 32'h0);
    chkIrq("R4 final idle", 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nErrs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

endmodule